// File: doc/BRIEF.md
# Event-Done Interrupt Coordinator

This block sits on one processor board in a system where several boards take in the same event from a shared backplane. It decides when the board raises its event-complete interrupt. The transfer engine holds a level that says the whole event has been sent. Each board drives its share of an open-collector "FIFO empty" line, so that line reads true only when every contributing board has drained its input. The event-done cause is raised when both the end-of-event level and the selected empty indication are true. The block also produces a separate message-interrupt cause, issues the GO command that starts a load, and turns a register write into a hardware reset request of fixed length.

Software uses a small register port to reach four locations. MASK (address 0) sets whether this board pulls the shared line, whether it takes the event-done interrupt, whether it uses its own FIFO status instead of the shared line, and whether it takes the message interrupt. STATUS (address 1) holds the two cause bits and is cleared by writing 1 to a bit. A write to CONTROL (address 2) issues GO. A write to RESET (address 3) requests a board reset. All mask bits clear on reset, so a board takes no part in the data flow until software enables it.

There are two state machines. The condition tracker has the states EV_ARMED and EV_FIRED. The transition ARMED to FIRED is taken when the combined condition is true. The transition FIRED to ARMED is taken when the condition is false, and this is the re-arm. The reset-pulse generator has the states RP_IDLE and RP_ACTIVE. The transition IDLE to ACTIVE is taken on a reset write. The transition ACTIVE to IDLE is taken when the length counter reaches its final value.

Top module: `evd_irq_ctrl`

## Requirements
- R1: Writing 1 to bit 0 at address 2 makes `go_o` high for exactly one cycle. It rises on the clock edge that accepts the write.
- R2: A rising edge on `start_load_i` gives exactly one `go_o` pulse one cycle later. Holding the line high gives no further pulses.
- R3: `shared_pull_low_o` is high only when MASK bit 0 (drive enable) is 1 and `local_empty_i` is 0. With bit 0 clear it stays low in every case.
- R4: With MASK bit 1 (event-done enable) set, STATUS bit 0 is set on the first clock edge where `eoe_level_i` and the selected empty indication are both 1. `irq_o` is then high.
- R5: While the combined condition stays true, STATUS bit 0 is not set again after it has been cleared. It can be set again only after the condition has gone false for at least one cycle.
- R6: With MASK bit 1 clear, the combined condition never sets STATUS bit 0, and the event-done cause does not drive `irq_o`.
- R7: With MASK bit 2 (local mode) set, `local_empty_i` replaces `shared_empty_i` in the combined condition.
- R8: With MASK bit 3 (message enable) set, a rising edge on `ext_msg_i` sets STATUS bit 1 and raises `irq_o`. STATUS bit 0 is left unchanged.
- R9: Writing to STATUS clears each bit whose write-data bit is 1 and leaves the other bits as they are. `irq_o` equals the OR of the set cause bits that are enabled.
- R10: Writing 1 to bit 0 at address 3 makes `reset_req_o` high for exactly 16 cycles. A second such write while the pulse is running does not extend it.
- R11: After reset, MASK and STATUS read 0, and `go_o`, `irq_o`, `reset_req_o` and `shared_pull_low_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 MASK, 1 STATUS, 2 CONTROL, 3 RESET) |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data for the current address |
| start_load_i | input | 1 | Load-start line; a rising edge issues GO |
| eoe_level_i | input | 1 | End-of-event level from the backplane |
| local_empty_i | input | 1 | This board's input FIFO is empty |
| shared_empty_i | input | 1 | Resolved wired-AND FIFO-empty line |
| ext_msg_i | input | 1 | External message interrupt request |
| shared_pull_low_o | output | 1 | Pull-low enable for the shared empty line |
| go_o | output | 1 | One-cycle GO pulse to the transfer engine |
| irq_o | output | 1 | Interrupt request to the processor |
| reset_req_o | output | 1 | Board hardware reset request pulse |

## Verification
The hardest case to reach from the ports is the re-arm window. A cause has been cleared, the combined condition is still held true, and the condition must then drop and rise again before the cause may come back. The directed stimulus holds both the end-of-event level and the empty line high and clears STATUS while they stay high. It checks that nothing comes back, then lowers only the end-of-event level for a single cycle and raises it again. A reset write issued while the reset pulse is already running is timed in the same way, so the bench can count the total width of the pulse.

// File: rtl/evd_pkg.sv
package evd_pkg;
    localparam int DATA_W = 4;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_MASK   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_RESET  = 2'd3;

    // mask bit positions
    localparam int MB_DRIVE = 0;
    localparam int MB_EVD   = 1;
    localparam int MB_LOCAL = 2;
    localparam int MB_MSG   = 3;

    // status bit positions
    localparam int SB_EVD = 0;
    localparam int SB_MSG = 1;

    typedef enum logic {EV_ARMED, EV_FIRED} ev_state_t;
    typedef enum logic {RP_IDLE, RP_ACTIVE} rp_state_t;
endpackage

// File: rtl/evd_regs.sv
module evd_regs
    import evd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              set_evd,
    input  logic              set_msg,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [1:0]        cause_q,
    output logic              go_wr,
    output logic              rst_wr
);
    logic wr_mask, wr_stat;
    logic [1:0] cause_d;

    assign wr_mask = reg_wr && (reg_addr == ADR_MASK);
    assign wr_stat = reg_wr && (reg_addr == ADR_STATUS);
    assign go_wr   = reg_wr && (reg_addr == ADR_CTRL)  && reg_wdata[0];
    assign rst_wr  = reg_wr && (reg_addr == ADR_RESET) && reg_wdata[0];

    always_comb begin
        cause_d = cause_q;
        if (wr_stat) cause_d = cause_d & ~reg_wdata[1:0];
        if (set_evd) cause_d[SB_EVD] = 1'b1;   // a new event wins over a clear
        if (set_msg) cause_d[SB_MSG] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            cause_q <= '0;
        end else begin
            if (wr_mask) mask_q <= reg_wdata;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_MASK:   reg_rdata = mask_q;
            ADR_STATUS: reg_rdata = {{(DATA_W-2){1'b0}}, cause_q};
            default:    reg_rdata = '0;
        endcase
    end

    AST_EVD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        set_evd |=> cause_q[SB_EVD]) else $error("evd cause not latched"); // R4
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[SB_MSG] && !set_msg) |=> !cause_q[SB_MSG]) else $error("w1c failed"); // R9
endmodule

// File: rtl/evd_cond_fsm.sv
module evd_cond_fsm
    import evd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic evd_en,
    output logic set_evd
);
    ev_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EV_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        set_evd = 1'b0;
        unique case (state_q)
            EV_ARMED: if (cond) begin
                state_d = EV_FIRED;
                set_evd = evd_en;
            end
            EV_FIRED: if (!cond) state_d = EV_ARMED;
            default:  state_d = EV_ARMED;
        endcase
    end

    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        set_evd |=> !set_evd) else $error("second set while held"); // R5
    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_FIRED && cond) |=> !set_evd) else $error("fired while held"); // R5
endmodule

// File: rtl/evd_pulse_gen.sv
module evd_pulse_gen
    import evd_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    rp_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE:   if (trig) state_d = RP_ACTIVE;
            RP_ACTIVE: if (cnt_q == LAST) state_d = RP_IDLE;
            default:   state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RP_ACTIVE) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end

    assign pulse = (state_q == RP_ACTIVE);

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> ($past(cnt_q) == LAST)) else $error("bad pulse length"); // R10
endmodule

// File: rtl/evd_irq_ctrl.sv
module evd_irq_ctrl
    import evd_pkg::*;
#(
    parameter int RST_PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [3:0]        reg_wdata,
    output logic [3:0]        reg_rdata,
    input  logic              start_load_i,
    input  logic              eoe_level_i,
    input  logic              local_empty_i,
    input  logic              shared_empty_i,
    input  logic              ext_msg_i,
    output logic              shared_pull_low_o,
    output logic              go_o,
    output logic              irq_o,
    output logic              reset_req_o
);
    logic [DATA_W-1:0] mask_q;
    logic [1:0]        cause_q;
    logic go_wr, rst_wr, set_evd, set_msg, cond, empty_sel;
    logic start_q, msg_q;

    evd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .set_evd(set_evd), .set_msg(set_msg),
        .reg_rdata(reg_rdata), .mask_q(mask_q), .cause_q(cause_q),
        .go_wr(go_wr), .rst_wr(rst_wr)
    );

    assign empty_sel = mask_q[MB_LOCAL] ? local_empty_i : shared_empty_i;
    assign cond      = eoe_level_i && empty_sel;

    evd_cond_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cond(cond),
        .evd_en(mask_q[MB_EVD]), .set_evd(set_evd)
    );

    evd_pulse_gen #(.PULSE_LEN(RST_PULSE_LEN)) u_rst (
        .clk(clk), .rst_n(rst_n), .trig(rst_wr), .pulse(reset_req_o)
    );

    assign set_msg = ext_msg_i && !msg_q && mask_q[MB_MSG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            msg_q   <= 1'b0;
            go_o    <= 1'b0;
        end else begin
            start_q <= start_load_i;
            msg_q   <= ext_msg_i;
            go_o    <= go_wr || (start_load_i && !start_q);
        end
    end

    // open-collector share: pull low only while enabled and still holding data
    assign shared_pull_low_o = mask_q[MB_DRIVE] && !local_empty_i;

    assign irq_o = (cause_q[SB_EVD] && mask_q[MB_EVD]) ||
                   (cause_q[SB_MSG] && mask_q[MB_MSG]);

    AST_PULL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        shared_pull_low_o |-> (!local_empty_i && mask_q[MB_DRIVE])) else $error("pull while empty"); // R3
    AST_START_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_load_i && !start_q) |=> go_o) else $error("no go on start edge"); // R2
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && !$past(go_wr) && start_load_i) |=> !go_o) else $error("go repeated"); // R2
    AST_MSG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_msg |=> (cause_q[SB_MSG] && irq_o)) else $error("msg not raised"); // R8
endmodule

// File: tb/test_evd_irq_ctrl.sv
module test_evd_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_wdata = 4'd0;
    logic [3:0] reg_rdata;
    logic start_load_i = 1'b0, eoe_level_i = 1'b0, local_empty_i = 1'b0;
    logic shared_empty_i = 1'b0, ext_msg_i = 1'b0;
    logic shared_pull_low_o, go_o, irq_o, reset_req_o;

    int tests = 0;
    int fails = 0;
    int rst_hi = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evd_irq_ctrl i_evd_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .start_load_i(start_load_i), .eoe_level_i(eoe_level_i),
        .local_empty_i(local_empty_i), .shared_empty_i(shared_empty_i),
        .ext_msg_i(ext_msg_i), .shared_pull_low_o(shared_pull_low_o),
        .go_o(go_o), .irq_o(irq_o), .reset_req_o(reset_req_o)
    );

    always @(negedge clk) if (reset_req_o) rst_hi <= rst_hi + 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // {mask[3:0], eoe, shared, local, exp_status_evd, exp_pull}
    localparam logic [8:0] VEC [9] = '{
        {4'h3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'h3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'h3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'h2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'h1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'h6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        logic [3:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        rd(2'd0, d); check("R11 mask", d, 4'h0);
        rd(2'd1, d); check("R11 status", d, 4'h0);
        check("R11 outs", {go_o, irq_o, reset_req_o, shared_pull_low_o}, 4'h0);

        // table: R3 R4 R6 R7
        for (int i = 0; i < 9; i++) begin
            eoe_level_i = 1'b0;
            wr(2'd0, VEC[i][8:5]);
            wr(2'd1, 4'h3);
            eoe_level_i = VEC[i][4]; shared_empty_i = VEC[i][3]; local_empty_i = VEC[i][2];
            @(negedge clk);
            rd(2'd1, d);
            check("R4/R6/R7 evd cause", {3'b0, d[0]}, {3'b0, VEC[i][1]});
            check("R4/R6 irq", {3'b0, irq_o}, {3'b0, VEC[i][1]});
            check("R3 pull", {3'b0, shared_pull_low_o}, {3'b0, VEC[i][0]});
        end

        // R5 no refire while held, re-arm after fall
        eoe_level_i = 1'b0; shared_empty_i = 1'b1; local_empty_i = 1'b1;
        wr(2'd0, 4'h3);
        wr(2'd1, 4'h3);
        eoe_level_i = 1'b1;
        @(negedge clk);
        wr(2'd1, 4'h1);
        repeat (3) @(negedge clk);
        rd(2'd1, d); check("R5 held no refire", d, 4'h0);
        check("R5 irq low", {3'b0, irq_o}, 4'h0);
        eoe_level_i = 1'b0;
        @(negedge clk);
        eoe_level_i = 1'b1;
        @(negedge clk);
        rd(2'd1, d); check("R5 rearm fires", d, 4'h1);

        // R8 message cause, R9 selective W1C
        wr(2'd0, 4'hB);
        ext_msg_i = 1'b1;
        @(negedge clk);
        rd(2'd1, d); check("R8 both causes", d, 4'h3);
        check("R8 irq", {3'b0, irq_o}, 4'h1);
        wr(2'd1, 4'h1);
        rd(2'd1, d); check("R9 clear evd only", d, 4'h2);
        check("R9 irq from msg", {3'b0, irq_o}, 4'h1);
        wr(2'd1, 4'h2);
        rd(2'd1, d); check("R9 all clear", d, 4'h0);
        check("R9 irq low", {3'b0, irq_o}, 4'h0);
        ext_msg_i = 1'b0;
        eoe_level_i = 1'b0;

        // R1 GO from control write
        wr(2'd2, 4'h1);
        check("R1 go pulse", {3'b0, go_o}, 4'h1);
        @(negedge clk);
        check("R1 go single", {3'b0, go_o}, 4'h0);
        wr(2'd2, 4'h0);
        check("R1 bit0 zero no go", {3'b0, go_o}, 4'h0);

        // R2 start_load edge
        start_load_i = 1'b1;
        @(negedge clk);
        check("R2 go on edge", {3'b0, go_o}, 4'h1);
        @(negedge clk);
        check("R2 no repeat", {3'b0, go_o}, 4'h0);
        @(negedge clk);
        check("R2 held", {3'b0, go_o}, 4'h0);
        start_load_i = 1'b0;

        // R10 reset pulse length, not extended
        rst_hi = 0;
        wr(2'd3, 4'h1);
        repeat (4) @(negedge clk);
        wr(2'd3, 4'h1);
        repeat (30) @(negedge clk);
        check("R10 pulse length", rst_hi[3:0], 4'h0);
        check("R10 pulse length hi", {3'b0, rst_hi == 16}, 4'h1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule